// File: doc/BRIEF.md
# NOR Flash Erase Sequencer

This block clears a byte range of a serial NOR flash by issuing a sequence of sector and block erase commands over a byte-level SPI transaction port. A request carries a start offset, a byte count, an addressing-width flag, a permission to use large blocks and a permission to skip regions that are already blank. The block breaks the range into steps, one at a time. Before each step it polls the flash status until the device is idle. It then optionally reads the step's region to see whether an erase is needed. After that it sets the write-enable latch, confirms that the latch is set, and sends the erase command.

The transaction port moves one byte at a time. The sequencer pulses `spi_go` with a byte and a frame-end flag. The serializer answers with a `spi_done` pulse that carries the byte it received and a failure flag. Chip select is released after each byte marked as the frame end. When the last step has been sent, the block waits for the flash to go idle once more and then pulses `done`. `err` or `tmo` are valid alongside `done`.

Top module: `nor_erase_seq`

## Requirements
- R1: A request whose offset or size has any of bits 11:0 set, or whose size is below 4096, ends on the next cycle with `done` and `err` high and no SPI traffic.
- R2: Each erase is preceded by status reads (opcode 0x05, second byte returns status, bit 0 = busy) until busy is clear, then a write-enable frame (opcode 0x06).
- R3: After write enable, a status read must show bit 1 (write-enable latch) set; otherwise the request ends with `err` and no erase is sent.
- R4: Each step uses opcode 0xD8 over 65536 bytes when large blocks are permitted, the current offset is 65536-aligned and at least 65536 bytes remain. Otherwise it uses opcode 0x20 over 4096 bytes. The choice is made again for every step.
- R5: The address follows the opcode most significant byte first. It is 4 bytes in wide mode and the low 3 bytes otherwise, so an erase frame is 5 or 4 bytes long.
- R6: With blank skipping enabled, the step region is read with opcode 0x03 (address as in R5, then CHUNK_BYTES data bytes per frame). If every byte is 0xFF, the erase is skipped. The first chunk that holds any other value leads straight to the erase.
- R7: A transport failure during a blank-check read does not end the request; the erase for that step is performed.
- R8: After the last erase, status is polled until busy clears before `done` is pulsed.
- R9: If a wait has lasted at least TIMEOUT_CYC cycles when a status read still shows busy, the request ends with `done` and `tmo` high.
- R10: Status reads that follow a busy result start at least POLL_GAP_CYC cycles after the previous status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, taken while idle |
| offset | input | 32 | First byte to erase |
| size | input | 32 | Number of bytes to erase |
| addr4 | input | 1 | Send 4 address bytes instead of 3 |
| blk_en | input | 1 | Permit 64 KiB block erases |
| blank_en | input | 1 | Read each region first and skip it if blank |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Request rejected or failed; valid with done |
| tmo | output | 1 | Busy wait expired; valid with done |
| spi_go | output | 1 | Byte request to the serializer |
| spi_tx | output | 8 | Byte to send |
| spi_last | output | 1 | Release chip select after this byte |
| spi_done | input | 1 | Byte exchange finished |
| spi_rx | input | 8 | Byte received |
| spi_fail | input | 1 | Exchange failed; valid with spi_done |

## Verification
The hardest case to reach from the ports is a blank check that scans a whole chunked region and finds a single non-blank byte only in the very last data byte. A scan that stopped early or compared too few bytes would look correct for almost any other contents. The bench's flash model marks sectors as dirty only at their final byte and mixes blank and dirty sectors in one request. It also forces transport failures only on read frames, which reaches the fall-through path without disturbing the status and erase traffic.

// File: rtl/nor_erase_seq.sv
module nor_erase_seq #(
  parameter int CHUNK_BYTES  = 256,
  parameter int POLL_GAP_CYC = 1000,
  parameter int TIMEOUT_CYC  = 4000000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] offset,
  input  logic [31:0] size,
  input  logic        addr4,
  input  logic        blk_en,
  input  logic        blank_en,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic        tmo,
  output logic        spi_go,
  output logic [7:0]  spi_tx,
  output logic        spi_last,
  input  logic        spi_done,
  input  logic [7:0]  spi_rx,
  input  logic        spi_fail
);
  localparam int IDX_W = $clog2(CHUNK_BYTES + 6);
  localparam int GAP_W = $clog2(POLL_GAP_CYC + 1);
  localparam int TMO_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [7:0] OP_WREN = 8'h06, OP_STAT = 8'h05, OP_READ = 8'h03;
  localparam logic [7:0] OP_SEC = 8'h20, OP_BLK = 8'hD8;
  localparam logic [31:0] SEC_B = 32'h1000, BLK_B = 32'h10000;

  typedef enum logic [2:0] {S_IDLE, S_POLL, S_GAP, S_SCAN, S_WREN, S_WELCHK, S_ERASE} st_t;
  st_t state;

  logic [31:0] cur_off, left, scan_off, scan_left;
  logic [IDX_W-1:0] idx, len_m1;
  logic [GAP_W-1:0] gap_cnt;
  logic [TMO_W-1:0] wait_cnt;
  logic mode4, blk_r, scan_r, big, final_w, waiting, tfail, blank;
  logic [7:0] op;

  wire [2:0]  ab       = mode4 ? 3'd4 : 3'd3;
  wire [31:0] taddr    = (state == S_SCAN) ? scan_off : cur_off;
  wire [2:0]  bsel     = ab - idx[2:0];
  wire [31:0] addr_sh  = taddr >> {bsel, 3'b000};
  wire        in_txn   = (state != S_IDLE) && (state != S_GAP);
  wire        is_data  = idx > IDX_W'(ab);
  wire        big_sel  = blk_r && (cur_off[15:0] == 16'h0) && (left >= BLK_B);
  wire [31:0] step     = big ? BLK_B : SEC_B;
  wire        bad      = (|offset[11:0]) || (|size[11:0]) || (size < SEC_B);
  wire        fail_now = tfail | spi_fail;
  wire        blank_now = blank & (!is_data | (spi_rx == 8'hFF));
  wire        byte_end = waiting && spi_done;

  always_comb begin
    op = OP_STAT;
    len_m1 = IDX_W'(1);
    case (state)
      S_WREN:  begin op = OP_WREN; len_m1 = '0; end
      S_ERASE: begin op = big ? OP_BLK : OP_SEC; len_m1 = IDX_W'(ab); end
      S_SCAN:  begin op = OP_READ; len_m1 = IDX_W'(ab) + IDX_W'(CHUNK_BYTES); end
      default: ;
    endcase
  end

  assign busy     = state != S_IDLE;
  assign spi_go   = in_txn && !waiting;
  assign spi_last = idx == len_m1;
  assign spi_tx   = (idx == '0) ? op : (is_data ? 8'h00 : addr_sh[7:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cur_off <= '0; left <= '0; scan_off <= '0; scan_left <= '0;
      idx <= '0; gap_cnt <= '0; wait_cnt <= '0;
      mode4 <= 1'b0; blk_r <= 1'b0; scan_r <= 1'b0; big <= 1'b0;
      final_w <= 1'b0; waiting <= 1'b0; tfail <= 1'b0; blank <= 1'b0;
      done <= 1'b0; err <= 1'b0; tmo <= 1'b0;
    end else begin
      done <= 1'b0;
      if ((state == S_POLL || state == S_GAP) && wait_cnt != '1)
        wait_cnt <= wait_cnt + 1'b1;
      if (spi_go) waiting <= 1'b1;
      case (state)
        S_IDLE: if (start) begin
          err <= 1'b0;
          tmo <= 1'b0;
          if (bad) begin
            done <= 1'b1;
            err <= 1'b1;
          end else begin
            cur_off <= offset;
            left <= size;
            mode4 <= addr4;
            blk_r <= blk_en;
            scan_r <= blank_en;
            final_w <= 1'b0;
            wait_cnt <= '0;
            idx <= '0;
            tfail <= 1'b0;
            state <= S_POLL;
          end
        end
        S_GAP:
          if (gap_cnt == '0) state <= S_POLL;
          else gap_cnt <= gap_cnt - 1'b1;
        default: if (byte_end) begin
          waiting <= 1'b0;
          if (!spi_last) begin
            idx <= idx + 1'b1;
            tfail <= fail_now;
            blank <= blank_now;
          end else begin
            idx <= '0;
            tfail <= 1'b0;
            case (state)
              S_POLL:
                if (fail_now) begin
                  state <= S_IDLE; done <= 1'b1; err <= 1'b1;
                end else if (spi_rx[0]) begin
                  if (wait_cnt >= TMO_W'(TIMEOUT_CYC)) begin
                    state <= S_IDLE; done <= 1'b1; tmo <= 1'b1;
                  end else begin
                    gap_cnt <= GAP_W'(POLL_GAP_CYC);
                    state <= S_GAP;
                  end
                end else if (final_w) begin
                  state <= S_IDLE; done <= 1'b1;
                end else begin
                  big <= big_sel;
                  if (scan_r) begin
                    scan_off <= cur_off;
                    scan_left <= big_sel ? BLK_B : SEC_B;
                    blank <= 1'b1;
                    state <= S_SCAN;
                  end else state <= S_WREN;
                end
              S_SCAN:
                if (fail_now || !blank_now) state <= S_WREN;
                else if (scan_left == 32'(CHUNK_BYTES)) begin
                  cur_off <= cur_off + step;
                  left <= left - step;
                  final_w <= left == step;
                  wait_cnt <= '0;
                  state <= S_POLL;
                end else begin
                  scan_off <= scan_off + 32'(CHUNK_BYTES);
                  scan_left <= scan_left - 32'(CHUNK_BYTES);
                  blank <= 1'b1;
                end
              S_WREN:
                if (fail_now) begin
                  state <= S_IDLE; done <= 1'b1; err <= 1'b1;
                end else state <= S_WELCHK;
              S_WELCHK:
                if (fail_now || !spi_rx[1]) begin
                  state <= S_IDLE; done <= 1'b1; err <= 1'b1;
                end else state <= S_ERASE;
              S_ERASE:
                if (fail_now) begin
                  state <= S_IDLE; done <= 1'b1; err <= 1'b1;
                end else begin
                  cur_off <= cur_off + step;
                  left <= left - step;
                  final_w <= left == step;
                  wait_cnt <= '0;
                  state <= S_POLL;
                end
              default: state <= S_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  AST_BAD_REQ_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state == S_IDLE && bad) |=> (done && err && !spi_go)); // R1
  AST_ERASE_AFTER_LATCH_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ERASE && $past(state) != S_ERASE) |-> $past(state) == S_WELCHK); // R3
  AST_TMO_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo) |-> $past(wait_cnt) >= TMO_W'(TIMEOUT_CYC)); // R9
  AST_GAP_ELAPSED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_POLL && $past(state) == S_GAP) |-> $past(gap_cnt) == '0); // R10
  AST_DONE_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !spi_go)); // R8
endmodule

// File: tb/nor_erase_seq_test.sv
module nor_erase_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int CHUNK = 256;
  localparam int GAP = 20;
  localparam int TMO = 2000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, addr4 = 1'b0, blk_en = 1'b0, blank_en = 1'b0;
  logic [31:0] offset = '0, size = '0;
  logic busy, done, err, tmo, spi_go, spi_last;
  logic [7:0] spi_tx;
  logic spi_done = 1'b0, spi_fail = 1'b0;
  logic [7:0] spi_rx = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_erase_seq #(.CHUNK_BYTES(CHUNK), .POLL_GAP_CYC(GAP), .TIMEOUT_CYC(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .offset(offset), .size(size),
    .addr4(addr4), .blk_en(blk_en), .blank_en(blank_en), .busy(busy), .done(done),
    .err(err), .tmo(tmo), .spi_go(spi_go), .spi_tx(spi_tx), .spi_last(spi_last),
    .spi_done(spi_done), .spi_rx(spi_rx), .spi_fail(spi_fail));

  int checks = 0, failures = 0;
  int cyc = 0, busy_cnt = 0, m_ab = 3, fidx = 0, n_er = 0, viol = 0, gap_viol = 0, last_poll = 0;
  logic stuck = 1'b0, wel_broken = 1'b0, fail_rd = 1'b0, wel = 1'b0, last_busy = 1'b0;
  logic pend = 1'b0, cap_last = 1'b0;
  int dly = 0;
  logic [7:0] cap_tx, fop, resp;
  logic [31:0] faddr, ra;
  logic [63:0] dirty = '0;
  logic [7:0] lg_op [0:31];
  logic [31:0] lg_addr [0:31];
  int lg_len [0:31];

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (busy_cnt > 0) busy_cnt = busy_cnt - 1;
    spi_done <= 1'b0;
    if (pend) begin
      if (dly > 0) dly = dly - 1;
      else begin
        resp = 8'hFF;
        if (fidx == 0) begin
          fop = cap_tx;
          faddr = '0;
          if (cap_tx == 8'h05) begin
            if (last_busy && (cyc - last_poll) < GAP) gap_viol = gap_viol + 1;
            last_poll = cyc;
          end
          if (cap_tx == 8'h06 && (stuck || busy_cnt > 0)) viol = viol + 1;
        end else if (fidx <= m_ab) faddr = {faddr[23:0], cap_tx};
        if (fop == 8'h05 && fidx >= 1) begin
          resp = {6'b0, wel, stuck || busy_cnt > 0};
          last_busy = stuck || busy_cnt > 0;
        end
        if (fop == 8'h03 && fidx > m_ab) begin
          ra = faddr + 32'(fidx - 1 - m_ab);
          resp = (dirty[ra[17:12]] && ra[11:0] == 12'hFFF) ? 8'h00 : 8'hFF;
        end
        spi_rx <= resp;
        spi_fail <= fail_rd && fop == 8'h03;
        spi_done <= 1'b1;
        if (cap_last) begin
          if (fop == 8'h06 && !wel_broken) wel = 1'b1;
          if (fop == 8'h20 || fop == 8'hD8) begin
            if (!wel || stuck || busy_cnt > 0) viol = viol + 1;
            if (n_er < 32) begin
              lg_op[n_er] = fop; lg_addr[n_er] = faddr; lg_len[n_er] = fidx + 1;
            end
            n_er = n_er + 1;
            wel = 1'b0;
            busy_cnt = (fop == 8'hD8) ? 400 : 150;
            if (fop == 8'hD8) for (int k = 0; k < 16; k++) dirty[{faddr[17:16], 4'(k)}] = 1'b0;
            else dirty[faddr[17:12]] = 1'b0;
          end
          fidx = 0;
        end else fidx = fidx + 1;
        pend = 1'b0;
      end
    end else if (spi_go) begin
      pend = 1'b1; dly = 1; cap_tx = spi_tx; cap_last = spi_last;
    end
  end

  task automatic chk(input logic ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic model_init(input int ab);
    m_ab = ab; n_er = 0; viol = 0; gap_viol = 0; stuck = 1'b0; wel_broken = 1'b0;
    fail_rd = 1'b0; wel = 1'b0; last_busy = 1'b0; dirty = '0;
  endtask

  int t_run;
  task automatic run(input logic [31:0] o, input logic [31:0] s, input logic a4,
                     input logic bk, input logic bl);
    int n;
    @(negedge clk);
    offset = o; size = s; addr4 = a4; blk_en = bk; blank_en = bl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t_run = 1;
    n = 0;
    while (!done && n < 60000) begin @(negedge clk); n++; t_run++; end
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", n);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic t_reset();
    chk(!busy && !done && !spi_go && !err && !tmo, "reset R8", {busy, done, spi_go}, 0);
  endtask

  task automatic t_reject();
    model_init(3);
    run(32'h800, 32'h1000, 0, 0, 0);
    chk(t_run == 1 && err && !tmo, "R1 misaligned offset", {err, tmo}, 2);
    run(32'h1000, 32'h1800, 0, 0, 0);
    chk(err, "R1 size not multiple", err, 1);
    run(32'h1000, 32'h0, 0, 0, 0);
    chk(err, "R1 zero size", err, 1);
    chk(n_er == 0 && cap_tx !== 8'h05, "R1 no traffic", n_er, 0);
  endtask

  task automatic t_narrow();
    model_init(3);
    run(32'h5A023000, 32'h2000, 0, 1, 0);
    chk(!err && !tmo && n_er == 2, "R4 two sector erases", n_er, 2);
    chk(lg_op[0] == 8'h20 && lg_addr[0] == 32'h023000 && lg_len[0] == 4, "R5 3-byte address", lg_addr[0], 32'h023000);
    chk(lg_addr[1] == 32'h024000 && lg_len[1] == 4, "R5 second step", lg_addr[1], 32'h024000);
    chk(viol == 0, "R2 wait and latch before erase", viol, 0);
    chk(busy_cnt == 0, "R8 final wait", busy_cnt, 0);
  endtask

  task automatic t_block();
    model_init(4);
    run(32'h5A010000, 32'h11000, 1, 1, 0);
    chk(n_er == 2 && lg_op[0] == 8'hD8, "R4 block first", lg_op[0], 8'hD8);
    chk(lg_addr[0] == 32'h5A010000 && lg_len[0] == 5, "R5 4-byte address", lg_addr[0], 32'h5A010000);
    chk(lg_op[1] == 8'h20 && lg_addr[1] == 32'h5A020000, "R4 sector remainder", lg_addr[1], 32'h5A020000);
    chk(viol == 0 && busy_cnt == 0, "R2 R8 block run", viol, 0);
  endtask

  task automatic t_mixed();
    model_init(3);
    run(32'h0F000, 32'h11000, 0, 1, 0);
    chk(n_er == 2 && lg_op[0] == 8'h20 && lg_op[1] == 8'hD8 && lg_addr[1] == 32'h10000,
        "R4 per-step choice", {lg_op[0], lg_op[1]}, 16'h20D8);
    model_init(3);
    run(32'h10000, 32'h10000, 0, 0, 0);
    chk(n_er == 16 && lg_op[15] == 8'h20 && lg_addr[15] == 32'h1F000, "R4 blocks disabled", n_er, 16);
  endtask

  task automatic t_blank();
    model_init(3);
    dirty[3] = 1'b1;
    run(32'h2000, 32'h2000, 0, 0, 1);
    chk(!err && n_er == 1 && lg_addr[0] == 32'h3000, "R6 skip blank erase dirty", lg_addr[0], 32'h3000);
    chk(dirty[3] == 1'b0, "R6 dirty sector cleared", dirty[3], 0);
    model_init(3);
    run(32'h5000, 32'h1000, 0, 0, 1);
    chk(!err && !tmo && n_er == 0, "R6 all blank skipped", n_er, 0);
  endtask

  task automatic t_readfail();
    model_init(3);
    fail_rd = 1'b1;
    run(32'h6000, 32'h1000, 0, 0, 1);
    chk(!err && n_er == 1 && lg_addr[0] == 32'h6000, "R7 read failure falls through", n_er, 1);
  endtask

  task automatic t_wel();
    model_init(3);
    wel_broken = 1'b1;
    run(32'h1000, 32'h1000, 0, 0, 0);
    chk(err && !tmo && n_er == 0, "R3 latch not set", {err, n_er[3:0]}, 5'h10);
  endtask

  task automatic t_timeout();
    model_init(3);
    stuck = 1'b1;
    run(32'h1000, 32'h1000, 0, 0, 0);
    chk(tmo && !err && n_er == 0, "R9 timeout", {tmo, err}, 2);
    chk(t_run >= TMO, "R9 window length", t_run, TMO);
    chk(gap_viol == 0, "R10 poll spacing", gap_viol, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reject();
    t_narrow();
    t_block();
    t_mixed();
    t_blank();
    t_readfail();
    t_wel();
    t_timeout();
    chk(gap_viol == 0, "R10 overall spacing", gap_viol, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule